// File: doc/BRIEF.md
# Priority Crossbar Pin Assignment Decoder

This block decides which digital function drives each pin of a small I/O bank. Each peripheral that is switched on asks for one or more pins. The peripherals are served in a fixed priority order, and each floating function takes the lowest-numbered pin that is still free. Pins flagged in a skip mask are left out of that search, so software can reserve them for special signals such as crystal connections. The serial port is an exception to the search. Its transmit and receive lines always sit on two fixed pins, chosen by a build-time option, whatever the skip mask holds.

When every enabled function has been placed, each free pin that is not skipped becomes general-purpose I/O. For each pin the decoder gives a select code that names the function driving it. For each function it gives the pin index, which the input-side routing uses. An overflow flag is raised when an enabled function finds no free pin. All outputs are registered, so a change on the inputs shows up one clock edge later.

Top module: `xbar_pin_decoder`

## Requirements
- R1: Outputs are registered. After reset, every pin code is 30 (general-purpose), every function index is 7 (unconnected) and overflow is 0. A change on the inputs appears on the outputs at the next rising clock edge.
- R2: While `uart_en` is 1, UART TX (function 0) sits on pin 3 and UART RX (function 1) sits on pin 4, or on pins 4 and 5 when `UART_ALT_POS`=1. This holds even if those pins are skipped. Both lines are always assigned together.
- R3: An enabled function that finds no free pin reports index 7 and sets `overflow` to 1. When every enabled function is placed, `overflow` is 0.
- R4: Floating functions are placed in the following code order, each on the lowest free pin: SPI SCK 2, MISO 3, MOSI 4, NSS 5, two-wire SDA 6, SCL 7, LIN TX 8, LIN RX 9, comparator sync 10, comparator async 11, clock out 12, PCA CEX0 13, CEX1 14, CEX2 15, counter input 16, timer0 17, timer1 18.
- R5: A pin whose bit is set in `skip_mask` (bit n covers pin n) is never given to a floating function. Its code is 31 unless the UART holds it.
- R6: NSS (function 5) takes a pin only when `spi_four_wire` is 1. In 3-wire mode it reports index 7 and uses no pin.
- R7: Enabling the two-wire bus places SDA and SCL as a pair. Enabling LIN places TX and RX as a pair.
- R8: Every pin that is neither assigned nor skipped has code 30. These pins therefore follow the placed functions, counting up from pin 0.
- R9: `pca_chans` = n enables CEX0 through CEX(n-1). The value 0 enables none.
- R10: Whenever function f reports pin index i other than 7, the code of pin i is f.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| uart_en | input | 1 | Serial port enable (TX and RX) |
| spi_en | input | 1 | SPI enable |
| spi_four_wire | input | 1 | 1 = SPI uses NSS |
| twi_en | input | 1 | Two-wire bus enable (SDA and SCL) |
| lin_en | input | 1 | LIN enable (TX and RX) |
| cmp_sync_en | input | 1 | Synchronous comparator output enable |
| cmp_async_en | input | 1 | Asynchronous comparator output enable |
| clkout_en | input | 1 | System clock output enable |
| pca_chans | input | 2 | Number of PCA channels routed (0 to 3) |
| ext_cnt_en | input | 1 | External counter input enable |
| tmr0_en | input | 1 | Timer 0 input enable |
| tmr1_en | input | 1 | Timer 1 input enable |
| skip_mask | input | 6 | Pins excluded from floating placement |
| pin_sel | output | 30 | Five-bit code per pin; pin n in bits [5n+4:5n] |
| func_pin | output | 57 | Three-bit pin index per function; function f in bits [3f+2:3f] |
| overflow | output | 1 | An enabled function could not be placed |

## Verification
Two functions of the block can land on the same pin in one cycle. The first is the fixed UART placement meeting a skip bit on the same pin: the bench sets `uart_en` together with skip bits on pins 3 and 4, and it expects the UART codes to win while the other skipped pins read 31. The second is overflow raised in the same cycle as general-purpose fill: the bench turns on UART, 4-wire SPI and the two-wire bus together. It then checks that SDA and SCL report index 7, that `overflow` is 1 and that no pin is left as general-purpose. A scoreboard model checks every vector, including a long run of random enable and skip combinations applied on back-to-back cycles.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
   localparam int NFUNC = 19;
   localparam int SELW  = 5;

   localparam int F_UTX  = 0;
   localparam int F_URX  = 1;
   localparam int F_SCK  = 2;
   localparam int F_MISO = 3;
   localparam int F_MOSI = 4;
   localparam int F_NSS  = 5;
   localparam int F_SDA  = 6;
   localparam int F_SCL  = 7;
   localparam int F_LTX  = 8;
   localparam int F_LRX  = 9;
   localparam int F_CPS  = 10;
   localparam int F_CPA  = 11;
   localparam int F_CLKO = 12;
   localparam int F_CEX0 = 13;
   localparam int F_ECI  = 16;
   localparam int F_T0   = 17;
   localparam int F_T1   = 18;
   localparam int MAX_PCA = 3;

   localparam logic [SELW-1:0] SEL_GPIO = 5'd30;
   localparam logic [SELW-1:0] SEL_SKIP = 5'd31;
endpackage

// File: rtl/xbar_req_expand.sv
module xbar_req_expand import xbar_pkg::*; #(
   parameter int NPCA = 3,
   localparam int PCAW = $clog2(NPCA + 1)
) (
   input  logic             uart_en,
   input  logic             spi_en,
   input  logic             spi_four_wire,
   input  logic             twi_en,
   input  logic             lin_en,
   input  logic             cmp_sync_en,
   input  logic             cmp_async_en,
   input  logic             clkout_en,
   input  logic [PCAW-1:0]  pca_chans,
   input  logic             ext_cnt_en,
   input  logic             tmr0_en,
   input  logic             tmr1_en,
   output logic [NFUNC-1:0] req
);
   assign req[F_UTX]  = uart_en;
   assign req[F_URX]  = uart_en;
   assign req[F_SCK]  = spi_en;
   assign req[F_MISO] = spi_en;
   assign req[F_MOSI] = spi_en;
   assign req[F_NSS]  = spi_en & spi_four_wire;
   assign req[F_SDA]  = twi_en;
   assign req[F_SCL]  = twi_en;
   assign req[F_LTX]  = lin_en;
   assign req[F_LRX]  = lin_en;
   assign req[F_CPS]  = cmp_sync_en;
   assign req[F_CPA]  = cmp_async_en;
   assign req[F_CLKO] = clkout_en;
   assign req[F_ECI]  = ext_cnt_en;
   assign req[F_T0]   = tmr0_en;
   assign req[F_T1]   = tmr1_en;

   for (genvar c = 0; c < MAX_PCA; c++) begin : g_pca
      if (c < NPCA) begin : g_on
         assign req[F_CEX0 + c] = (pca_chans > PCAW'(c));
      end else begin : g_off
         assign req[F_CEX0 + c] = 1'b0;
      end
   end
endmodule

// File: rtl/xbar_alloc.sv
module xbar_alloc import xbar_pkg::*; #(
   parameter int NPIN   = 6,
   parameter int TX_PIN = 3,
   parameter int RX_PIN = 4,
   localparam int IDXW  = $clog2(NPIN + 1),
   localparam logic [IDXW-1:0] NONE = '1
) (
   input  logic [NFUNC-1:0]      req,
   input  logic [NPIN-1:0]       skip,
   output logic [NFUNC*IDXW-1:0] idx_flat,
   output logic [NFUNC-1:0]      miss
);
   logic [NFUNC:0][NPIN-1:0] busy;

   assign busy[0] = skip
                  | (req[F_UTX] ? (NPIN'(1) << TX_PIN) : '0)
                  | (req[F_URX] ? (NPIN'(1) << RX_PIN) : '0);

   for (genvar f = 0; f < NFUNC; f++) begin : g_stage
      if (f == F_UTX || f == F_URX) begin : g_fixed
         localparam int FIXP = (f == F_UTX) ? TX_PIN : RX_PIN;
         assign idx_flat[f*IDXW +: IDXW] = req[f] ? IDXW'(FIXP) : NONE;
         assign miss[f]     = 1'b0;
         assign busy[f+1]   = busy[f];
      end else begin : g_float
         logic [IDXW-1:0] pick;
         logic            hit;
         logic            take;
         always_comb begin
            hit  = 1'b0;
            pick = NONE;
            for (int p = NPIN - 1; p >= 0; p--) begin
               if (!busy[f][p]) begin
                  hit  = 1'b1;
                  pick = IDXW'(p);
               end
            end
         end
         assign take = req[f] & hit;
         assign idx_flat[f*IDXW +: IDXW] = take ? pick : NONE;
         assign miss[f]   = req[f] & ~hit;
         assign busy[f+1] = busy[f] | (take ? (NPIN'(1) << pick) : '0);
      end
   end
endmodule

// File: rtl/xbar_pin_code.sv
module xbar_pin_code import xbar_pkg::*; #(
   parameter int NPIN = 6,
   localparam int IDXW = $clog2(NPIN + 1)
) (
   input  logic [NFUNC*IDXW-1:0] idx_flat,
   input  logic [NPIN-1:0]       skip,
   output logic [NPIN*SELW-1:0]  sel_flat
);
   for (genvar p = 0; p < NPIN; p++) begin : g_pin
      logic [SELW-1:0] code;
      always_comb begin
         code = skip[p] ? SEL_SKIP : SEL_GPIO;
         for (int f = 0; f < NFUNC; f++) begin
            if (idx_flat[f*IDXW +: IDXW] == IDXW'(p)) code = SELW'(f);
         end
      end
      assign sel_flat[p*SELW +: SELW] = code;
   end
endmodule

// File: rtl/xbar_pin_decoder.sv
module xbar_pin_decoder import xbar_pkg::*; #(
   parameter int NPIN         = 6,
   parameter int UART_ALT_POS = 0,
   parameter int NPCA         = 3,
   localparam int IDXW   = $clog2(NPIN + 1),
   localparam int PCAW   = $clog2(NPCA + 1),
   localparam int TX_PIN = 3 + UART_ALT_POS,
   localparam int RX_PIN = TX_PIN + 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   uart_en,
   input  logic                   spi_en,
   input  logic                   spi_four_wire,
   input  logic                   twi_en,
   input  logic                   lin_en,
   input  logic                   cmp_sync_en,
   input  logic                   cmp_async_en,
   input  logic                   clkout_en,
   input  logic [PCAW-1:0]        pca_chans,
   input  logic                   ext_cnt_en,
   input  logic                   tmr0_en,
   input  logic                   tmr1_en,
   input  logic [NPIN-1:0]        skip_mask,
   output logic [NPIN*SELW-1:0]   pin_sel,
   output logic [NFUNC*IDXW-1:0]  func_pin,
   output logic                   overflow
);
   if (RX_PIN >= NPIN) begin : g_bad_bank
      $error("bank too small for fixed serial pins");
   end
   if (NPCA < 1 || NPCA > MAX_PCA) begin : g_bad_pca
      $error("NPCA out of range");
   end
   if (UART_ALT_POS != 0 && UART_ALT_POS != 1) begin : g_bad_alt
      $error("UART_ALT_POS must be 0 or 1");
   end

   logic [NFUNC-1:0]      req;
   logic [NFUNC*IDXW-1:0] idx_d;
   logic [NFUNC-1:0]      miss;
   logic [NPIN*SELW-1:0]  sel_d;

   xbar_req_expand #(.NPCA(NPCA)) u_req (
      .uart_en(uart_en), .spi_en(spi_en), .spi_four_wire(spi_four_wire),
      .twi_en(twi_en), .lin_en(lin_en), .cmp_sync_en(cmp_sync_en),
      .cmp_async_en(cmp_async_en), .clkout_en(clkout_en),
      .pca_chans(pca_chans), .ext_cnt_en(ext_cnt_en),
      .tmr0_en(tmr0_en), .tmr1_en(tmr1_en), .req(req)
   );

   xbar_alloc #(.NPIN(NPIN), .TX_PIN(TX_PIN), .RX_PIN(RX_PIN)) u_alloc (
      .req(req), .skip(skip_mask), .idx_flat(idx_d), .miss(miss)
   );

   xbar_pin_code #(.NPIN(NPIN)) u_code (
      .idx_flat(idx_d), .skip(skip_mask), .sel_flat(sel_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_sel  <= {NPIN{SEL_GPIO}};
         func_pin <= '1;
         overflow <= 1'b0;
      end else begin
         pin_sel  <= sel_d;
         func_pin <= idx_d;
         overflow <= |miss;
      end
   end
endmodule

// File: rtl/xbar_pin_decoder_chk.sv
module xbar_pin_decoder_chk import xbar_pkg::*; #(
   parameter int NPIN         = 6,
   parameter int UART_ALT_POS = 0,
   parameter int NPCA         = 3,
   localparam int IDXW   = $clog2(NPIN + 1),
   localparam int PCAW   = $clog2(NPCA + 1),
   localparam int TX_PIN = 3 + UART_ALT_POS,
   localparam int RX_PIN = TX_PIN + 1,
   localparam logic [IDXW-1:0] NONE = '1
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  uart_en,
   input logic                  spi_en,
   input logic                  spi_four_wire,
   input logic                  twi_en,
   input logic                  lin_en,
   input logic                  cmp_sync_en,
   input logic                  cmp_async_en,
   input logic                  clkout_en,
   input logic [PCAW-1:0]       pca_chans,
   input logic                  ext_cnt_en,
   input logic                  tmr0_en,
   input logic                  tmr1_en,
   input logic [NPIN-1:0]       skip_mask,
   input logic [NPIN*SELW-1:0]  pin_sel,
   input logic [NFUNC*IDXW-1:0] func_pin,
   input logic                  overflow
);
   logic armed;
   int   nreq;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   always_comb begin
      nreq = 2 * int'(uart_en) + 2 * int'(twi_en) + 2 * int'(lin_en)
           + int'(spi_en) * (3 + int'(spi_four_wire))
           + int'(cmp_sync_en) + int'(cmp_async_en) + int'(clkout_en)
           + int'(pca_chans) + int'(ext_cnt_en) + int'(tmr0_en) + int'(tmr1_en);
   end

   p_uart_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
      armed && $past(uart_en) |->
         func_pin[F_UTX*IDXW +: IDXW] == IDXW'(TX_PIN) &&
         func_pin[F_URX*IDXW +: IDXW] == IDXW'(RX_PIN));

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      armed && $past(nreq + $countones(skip_mask) <= NPIN) |-> !overflow);

   p_nss_3wire_r6: assert property (@(posedge clk) disable iff (!rst_n)
      armed && $past(!spi_four_wire) |-> func_pin[F_NSS*IDXW +: IDXW] == NONE);

   for (genvar p = 0; p < NPIN; p++) begin : g_pin_chk
      localparam bit UART_PIN = (p == TX_PIN) || (p == RX_PIN);
      p_skip_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
         armed && $past(skip_mask[p]) && !($past(uart_en) && UART_PIN) |->
            pin_sel[p*SELW +: SELW] == SEL_SKIP);
      p_code_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
         pin_sel[p*SELW +: SELW] < SELW'(NFUNC) ||
         pin_sel[p*SELW +: SELW] == SEL_GPIO ||
         pin_sel[p*SELW +: SELW] == SEL_SKIP);
   end

   for (genvar f = 0; f < NFUNC; f++) begin : g_fn_chk
      p_idx_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
         func_pin[f*IDXW +: IDXW] == NONE ||
         int'(func_pin[f*IDXW +: IDXW]) < NPIN);
      p_consistent_r10: assert property (@(posedge clk) disable iff (!rst_n)
         func_pin[f*IDXW +: IDXW] != NONE && int'(func_pin[f*IDXW +: IDXW]) < NPIN |->
            pin_sel[int'(func_pin[f*IDXW +: IDXW])*SELW +: SELW] == SELW'(f));
   end
endmodule

bind xbar_pin_decoder xbar_pin_decoder_chk #(
   .NPIN(NPIN), .UART_ALT_POS(UART_ALT_POS), .NPCA(NPCA)
) u_chk (
   .clk(clk), .rst_n(rst_n), .uart_en(uart_en), .spi_en(spi_en),
   .spi_four_wire(spi_four_wire), .twi_en(twi_en), .lin_en(lin_en),
   .cmp_sync_en(cmp_sync_en), .cmp_async_en(cmp_async_en),
   .clkout_en(clkout_en), .pca_chans(pca_chans), .ext_cnt_en(ext_cnt_en),
   .tmr0_en(tmr0_en), .tmr1_en(tmr1_en), .skip_mask(skip_mask),
   .pin_sel(pin_sel), .func_pin(func_pin), .overflow(overflow)
);

// File: tb/xbar_pin_decoder_tb_top.sv
module xbar_pin_decoder_tb_top;
   localparam int NPIN  = 6;
   localparam int NFUNC = 19;
   localparam int SELW  = 5;
   localparam int IDXW  = 3;

   typedef struct {
      logic [NPIN*SELW-1:0]  sel;
      logic [NFUNC*IDXW-1:0] idx;
      logic                  ovf;
      int                    stamp;
      string                 tag;
   } item_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic uart_en = 0, spi_en = 0, spi_four_wire = 0, twi_en = 0, lin_en = 0;
   logic cmp_sync_en = 0, cmp_async_en = 0, clkout_en = 0;
   logic [1:0] pca_chans = 0;
   logic ext_cnt_en = 0, tmr0_en = 0, tmr1_en = 0;
   logic [NPIN-1:0] skip_mask = 0;
   logic [NPIN*SELW-1:0]  pin_sel;
   logic [NFUNC*IDXW-1:0] func_pin;
   logic overflow;

   int nvec = 0, nfail = 0, cyc = 0;
   bit done = 0;
   item_t q[$];

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   xbar_pin_decoder dut_i (
      .clk(clk), .rst_n(rst_n), .uart_en(uart_en), .spi_en(spi_en),
      .spi_four_wire(spi_four_wire), .twi_en(twi_en), .lin_en(lin_en),
      .cmp_sync_en(cmp_sync_en), .cmp_async_en(cmp_async_en),
      .clkout_en(clkout_en), .pca_chans(pca_chans), .ext_cnt_en(ext_cnt_en),
      .tmr0_en(tmr0_en), .tmr1_en(tmr1_en), .skip_mask(skip_mask),
      .pin_sel(pin_sel), .func_pin(func_pin), .overflow(overflow)
   );

   // Reference model from the requirement text
   function automatic item_t model();
      item_t it;
      int owner[NPIN];
      bit want[NFUNC];
      it.ovf = 0;
      it.idx = '1;
      for (int f = 0; f < NFUNC; f++) want[f] = 0;
      want[2] = spi_en; want[3] = spi_en; want[4] = spi_en;
      want[5] = spi_en && spi_four_wire;
      want[6] = twi_en; want[7] = twi_en; want[8] = lin_en; want[9] = lin_en;
      want[10] = cmp_sync_en; want[11] = cmp_async_en; want[12] = clkout_en;
      for (int c = 0; c < 3; c++) want[13 + c] = (int'(pca_chans) > c);
      want[16] = ext_cnt_en; want[17] = tmr0_en; want[18] = tmr1_en;
      for (int p = 0; p < NPIN; p++) owner[p] = -1;
      if (uart_en) begin
         owner[3] = 0; owner[4] = 1;
         it.idx[0 +: IDXW] = 3'd3;
         it.idx[IDXW +: IDXW] = 3'd4;
      end
      for (int f = 2; f < NFUNC; f++) begin
         if (want[f]) begin
            bit placed = 0;
            for (int p = 0; p < NPIN; p++) begin
               if (!placed && owner[p] < 0 && !skip_mask[p]) begin
                  owner[p] = f;
                  it.idx[f*IDXW +: IDXW] = 3'(p);
                  placed = 1;
               end
            end
            if (!placed) it.ovf = 1;
         end
      end
      for (int p = 0; p < NPIN; p++)
         it.sel[p*SELW +: SELW] = (owner[p] >= 0) ? 5'(owner[p])
                                : (skip_mask[p] ? 5'd31 : 5'd30);
      return it;
   endfunction

   task automatic apply(input bit u, input bit s, input bit s4, input bit tw,
                        input bit ln, input bit cs, input bit ca, input bit ck,
                        input logic [1:0] pc, input bit ec, input bit t0,
                        input bit t1, input logic [NPIN-1:0] sk, input string tag);
      item_t it;
      @(posedge clk);
      #2;
      uart_en = u; spi_en = s; spi_four_wire = s4; twi_en = tw; lin_en = ln;
      cmp_sync_en = cs; cmp_async_en = ca; clkout_en = ck; pca_chans = pc;
      ext_cnt_en = ec; tmr0_en = t0; tmr1_en = t1; skip_mask = sk;
      it = model();
      it.stamp = cyc;
      it.tag = tag;
      q.push_back(it);
   endtask

   always @(negedge clk) begin
      if (q.size() > 0 && q[0].stamp < cyc) begin
         item_t it;
         it = q.pop_front();
         nvec++;
         if (pin_sel !== it.sel || func_pin !== it.idx || overflow !== it.ovf) begin
            nfail++;
            $display("FAIL %s: sel=%h idx=%h ovf=%b expected sel=%h idx=%h ovf=%b",
                     it.tag, pin_sel, func_pin, overflow, it.sel, it.idx, it.ovf);
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      nvec++;
      if (pin_sel !== {NPIN{5'd30}} || func_pin !== '1 || overflow !== 1'b0) begin
         nfail++;
         $display("FAIL R1 reset: sel=%h idx=%h ovf=%b expected sel=%h idx=all ones ovf=0",
                  pin_sel, func_pin, overflow, {NPIN{5'd30}});
      end
      rst_n = 1'b1;
      //     u s s4 tw ln cs ca ck pc ec t0 t1 skip
      apply(0,0,0, 0,0, 0,0,0, 0, 0,0,0, 6'b000000, "R8 idle all gpio");
      apply(1,0,0, 0,0, 0,0,0, 0, 0,0,0, 6'b000000, "R2 uart fixed");
      apply(1,0,0, 0,0, 0,0,0, 0, 0,0,0, 6'b011111, "R2 uart over skipped pins / R5");
      apply(0,1,0, 0,0, 0,0,0, 0, 0,0,0, 6'b000000, "R6 spi 3-wire no nss");
      apply(0,1,1, 0,0, 0,0,0, 0, 0,0,0, 6'b000000, "R6 spi 4-wire nss");
      apply(1,1,1, 0,0, 0,0,0, 0, 0,0,0, 6'b000000, "R4 spi around uart");
      apply(0,1,0, 0,0, 0,0,0, 0, 0,0,0, 6'b000011, "R5 skip low pins");
      apply(1,1,1, 1,0, 0,0,0, 0, 0,0,0, 6'b000000, "R3 overflow with fill");
      apply(0,0,0, 1,1, 0,0,0, 0, 0,0,0, 6'b000000, "R7 pairs");
      apply(0,0,0, 1,0, 0,0,0, 0, 0,0,0, 6'b111110, "R7 pair split by lack of pins / R3");
      apply(0,0,0, 0,0, 0,0,0, 2, 0,0,1, 6'b000000, "R9 two pca channels");
      apply(0,0,0, 0,0, 0,0,0, 3, 0,0,0, 6'b101010, "R9 three pca over skips");
      apply(0,0,0, 0,0, 1,1,1, 0, 1,1,0, 6'b000000, "R4 low priority order");
      apply(0,0,0, 0,0, 1,1,1, 3, 1,1,1, 6'b000000, "R3 all low priority overflow");
      apply(1,0,0, 0,0, 0,0,0, 0, 1,0,0, 6'b111111, "R10 uart with all skipped");
      apply(0,0,0, 0,0, 0,0,0, 0, 0,0,0, 6'b000000, "R1 return to idle");
      for (int i = 0; i < 400; i++) begin
         logic [31:0] r;
         r = $urandom;
         apply(r[0], r[1], r[2], r[3], r[4], r[5], r[6], r[7], r[9:8], r[10],
               r[11], r[12], (r[13] ? r[19:14] : 6'b0), "R4 R10 random");
      end
      repeat (3) @(posedge clk);
      finish_run();
   end
endmodule